// File: doc/BRIEF.md
# Tagged Add/Subtract Unit with Trap

This unit adds or subtracts two 32-bit words whose two least significant bits carry a type tag. A dynamically typed runtime keeps small integers with a zero tag, so arithmetic on them is only valid when both tags are zero and the signed result fits in 32 bits. The unit computes the result combinationally and checks both conditions. If either check fails, it raises a trap in the same cycle as the valid strobe.

Condition codes (negative, zero, overflow, carry) sit in a register. That register is loaded on the clock edge only when the operation is valid and does not trap. A trapping operation therefore leaves the previous flags in place, and the surrounding pipeline can restart cleanly after handling the trap. Trap dispatch and writeback of the result are handled elsewhere.

Top module: `tagged_arith_unit`

## Requirements
- R1: While `in_valid` is high, `trap` is high if bit 0 or bit 1 of either operand is set.
- R2: While `in_valid` is high with `op_sub` = 0, `trap` is high when the operands have equal sign bits (bit 31) and the result's sign bit differs from `opnd_a[31]`.
- R3: While `in_valid` is high with `op_sub` = 1, `trap` is high when the operand sign bits differ and the result's sign bit differs from `opnd_a[31]`.
- R4: `result` always equals `opnd_a + opnd_b` (with `op_sub` = 0) or `opnd_a - opnd_b` (with `op_sub` = 1), modulo 2^32, whether or not a trap is raised.
- R5: After a clock edge where `in_valid` is high and `trap` is low, `flags[3]` (N) equals bit 31 of that result and `flags[2]` (Z) is 1 exactly when that result was zero.
- R6: On a committed operation, `flags[0]` (C) is set for add when the unsigned result is below `opnd_a`, and for subtract when `opnd_a` is below `opnd_b` unsigned.
- R7: On a committed operation, `flags[1]` (V) is loaded as 0, because any overflowing operation traps instead of committing.
- R8: `flags` keep their value across any clock edge where `in_valid` is low or `trap` is high.
- R9: `trap` is low whenever `in_valid` is low.
- R10: Synchronous active-high `rst` clears `flags` to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| opnd_a | input | 32 | First operand (tag in bits 1:0) |
| opnd_b | input | 32 | Second operand (tag in bits 1:0) |
| result | output | 32 | Sum or difference (combinational) |
| trap | output | 1 | Tag-overflow trap, aligned with `in_valid` |
| flags | output | 4 | Registered condition codes {N,Z,V,C} |

## Verification
The assertions check the following on every cycle:
- Tag trap and overflow trap conditions.
- Trap silence while idle.
- Result arithmetic.
- The sign flag and cleared overflow flag after a commit.
- Flag hold after idle or trapping cycles.
- Reset clearing.

The carry and zero flags, and the sequences that show flags surviving a run of traps, can only be shown by the bench's scenarios:
- A sweep over all sixteen tag combinations.
- Overflow at both signs for add and subtract.
- A mid-run reset.

// File: rtl/tagalu_pkg.sv
package tagalu_pkg;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned TAG_W  = 2;
    localparam int unsigned MSB   = DATA_W - 1;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } arith_op_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } cc_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              ovf;
        logic              carry;
    } arith_out_t;

    function automatic logic tag_nonzero(input logic [DATA_W-1:0] w);
        return |w[TAG_W-1:0];
    endfunction
endpackage

// File: rtl/tagalu_tag_check.sv
module tagalu_tag_check
    import tagalu_pkg::*;
(
    input  logic [DATA_W-1:0] word_a,
    input  logic [DATA_W-1:0] word_b,
    output logic              tag_bad
);
    always_comb tag_bad = tag_nonzero(word_a) | tag_nonzero(word_b);
endmodule

// File: rtl/tagalu_arith.sv
module tagalu_arith
    import tagalu_pkg::*;
(
    input  arith_op_e         op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output arith_out_t        res
);
    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] dif_w;
    logic [DATA_W-1:0] ovf_vec;

    always_comb begin
        sum_w = src_a + src_b;
        dif_w = src_a - src_b;
        if (op == OP_SUB) begin
            res.value = dif_w;
            ovf_vec   = (src_a ^ src_b) & (src_a ^ dif_w);
            res.carry = src_a < src_b;
        end else begin
            res.value = sum_w;
            ovf_vec   = ~(src_a ^ src_b) & (src_a ^ sum_w);
            res.carry = sum_w < src_a;
        end
        res.ovf = ovf_vec[MSB];
    end
endmodule

// File: rtl/tagalu_cc_reg.sv
module tagalu_cc_reg
    import tagalu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  cc_t  cc_next,
    output cc_t  cc_q
);
    always_ff @(posedge clk) begin
        if (rst)         cc_q <= '0;
        else if (commit) cc_q <= cc_next;
    end
endmodule

// File: rtl/tagged_arith_unit.sv
module tagged_arith_unit
    import tagalu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              op_sub,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic              trap,
    output logic [3:0]        flags
);
    logic       tag_bad;
    arith_out_t ar;
    arith_op_e  op;
    cc_t        cc_next;
    cc_t        cc_q;
    logic       commit;

    assign op = op_sub ? OP_SUB : OP_ADD;

    tagalu_tag_check u_tag (
        .word_a  (opnd_a),
        .word_b  (opnd_b),
        .tag_bad (tag_bad)
    );

    tagalu_arith u_arith (
        .op    (op),
        .src_a (opnd_a),
        .src_b (opnd_b),
        .res   (ar)
    );

    always_comb begin
        trap          = in_valid & (tag_bad | ar.ovf);
        commit        = in_valid & ~trap;
        cc_next.neg   = ar.value[MSB];
        cc_next.zero  = (ar.value == '0);
        cc_next.ovf   = ar.ovf;
        cc_next.carry = ar.carry;
    end

    tagalu_cc_reg u_cc (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .cc_next (cc_next),
        .cc_q    (cc_q)
    );

    assign result = ar.value;
    assign flags  = cc_q;
endmodule

// File: rtl/tagged_arith_unit_chk.sv
module tagged_arith_unit_chk
    import tagalu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              op_sub,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [DATA_W-1:0] result,
    input logic              trap,
    input logic [3:0]        flags
);
    assert_tag_trap_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (opnd_a[1:0] != 2'b00 || opnd_b[1:0] != 2'b00)) |-> trap);

    assert_add_ovf_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_sub && opnd_a[MSB] == opnd_b[MSB] && result[MSB] != opnd_a[MSB]) |-> trap);

    assert_sub_ovf_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sub && opnd_a[MSB] != opnd_b[MSB] && result[MSB] != opnd_a[MSB]) |-> trap);

    assert_result_R4: assert property (@(posedge clk) disable iff (rst)
        result == (op_sub ? opnd_a - opnd_b : opnd_a + opnd_b));

    assert_neg_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !trap) |=> flags[3] == $past(result[MSB]));

    assert_no_ovf_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !trap) |=> !flags[1]);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || trap) |=> $stable(flags));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !trap);

    assert_reset_R10: assert property (@(posedge clk)
        rst |=> flags == 4'h0);
endmodule

bind tagged_arith_unit tagged_arith_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .op_sub   (op_sub),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .result   (result),
    .trap     (trap),
    .flags    (flags)
);

// File: tb/tagged_arith_unit_tb_top.sv
module tagged_arith_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        op_sub;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [31:0] result;
    logic        trap;
    logic [3:0]  flags;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    tagged_arith_unit dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .op_sub   (op_sub),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .result   (result),
        .trap     (trap),
        .flags    (flags)
    );

    typedef struct packed {
        logic        sub;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic        trp;
        logic [3:0]  fl;
    } vec_t;

    // flags after the edge; trapping rows carry the previous flags (R8)
    localparam vec_t VECS [12] = '{
        '{1'b0, 32'h0000_0004, 32'h0000_0008, 32'h0000_000C, 1'b0, 4'h0},
        '{1'b0, 32'hFFFF_FFFC, 32'h0000_0004, 32'h0000_0000, 1'b0, 4'h5},
        '{1'b0, 32'h7FFF_FFFC, 32'h0000_0004, 32'h8000_0000, 1'b1, 4'h5},
        '{1'b0, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 4'h5},
        '{1'b0, 32'h0000_0001, 32'h0000_0004, 32'h0000_0005, 1'b1, 4'h5},
        '{1'b1, 32'h0000_0008, 32'h0000_0004, 32'h0000_0004, 1'b0, 4'h0},
        '{1'b1, 32'h0000_0004, 32'h0000_0008, 32'hFFFF_FFFC, 1'b0, 4'h9},
        '{1'b1, 32'h8000_0000, 32'h0000_0004, 32'h7FFF_FFFC, 1'b1, 4'h9},
        '{1'b1, 32'h7FFF_FFFC, 32'hFFFF_FFFC, 32'h8000_0000, 1'b1, 4'h9},
        '{1'b1, 32'h0000_0010, 32'h0000_0010, 32'h0000_0000, 1'b0, 4'h4},
        '{1'b0, 32'h8000_0000, 32'hFFFF_FFFC, 32'h7FFF_FFFC, 1'b1, 4'h4},
        '{1'b0, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'hFFFF_FFE0, 1'b0, 4'h9}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive on negedge, check comb outputs, then flags after the posedge
    task automatic run_op(input logic v, input logic s, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] exp_res,
                          input logic exp_trp, input logic [3:0] exp_fl, input string req);
        @(negedge clk);
        in_valid = v; op_sub = s; opnd_a = a; opnd_b = b;
        #1;
        check({req, " R4 result"}, result, exp_res);
        check({req, " trap"}, {31'b0, trap}, {31'b0, exp_trp});
        @(posedge clk);
        #1;
        check({req, " flags"}, {28'b0, flags}, {28'b0, exp_fl});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [3:0] prev;
        rst = 1'b1; in_valid = 1'b0; op_sub = 1'b0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset flags", {28'b0, flags}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // table walk: R1 R2 R3 R5 R6 R7 R8
        foreach (VECS[i])
            run_op(1'b1, VECS[i].sub, VECS[i].a, VECS[i].b, VECS[i].res,
                   VECS[i].trp, VECS[i].fl, $sformatf("vec%0d R1/R2/R3/R5/R6/R8", i));

        // all tag combinations; prior flags are 9 (R1, R8)
        prev = 4'h9;
        for (int ta = 0; ta < 4; ta++) begin
            for (int tb = 0; tb < 4; tb++) begin
                logic bad;
                bad = (ta != 0) || (tb != 0);
                run_op(1'b1, 1'b0, 32'h100 | ta, 32'h200 | tb, 32'h300 + ta + tb,
                       bad, bad ? prev : 4'h0, $sformatf("tag a%0d b%0d R1", ta, tb));
                if (!bad) prev = 4'h0;
            end
        end

        // set flags to 9, then idle with bad tags: R9 and R8
        run_op(1'b1, 1'b1, 32'h4, 32'h8, 32'hFFFF_FFFC, 1'b0, 4'h9, "setup R6");
        run_op(1'b0, 1'b0, 32'h7FFF_FFFF, 32'h3, 32'h8000_0002, 1'b0, 4'h9, "idle R9");
        run_op(1'b0, 1'b1, 32'h0, 32'h4, 32'hFFFF_FFFC, 1'b0, 4'h9, "idle hold R8");

        // mid-run reset clears flags (R10)
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R10 mid-run reset", {28'b0, flags}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule